// File: doc/BRIEF.md
# Iterative Second-Order Servo Loop Filter

This block is one slow channel of a digital servo loop. It runs on a 125 MHz clock and takes a new sample at most once every 15 clocks. Each accepted sample passes through an input stage that either keeps the sample or replaces it with zero, and then adds an external offset. The sum is clamped by an input limiter. It is then filtered by a second-order IIR section and clamped again by an output limiter.

The IIR section computes its five products one after another on a single signed multiplier. Its coefficients are 36-bit fixed point with a fixed 2^16 denominator. Limits are 18-bit values aligned to the top of the 25-bit signal path. A hold input freezes the filter, and a clear input empties its delay line. Two flags report clipping and an output that rests on a limit. All coefficients and limits are plain inputs, assumed steady while samples are processed.

Top module: `servo_slow_chain`

## Requirements
- R1: The stage value is `(in_zero ? 0 : in_sample) + dx`, formed with one extra bit, so a sum beyond the 25-bit signed range clamps at the input limit and never wraps. `x_out` holds the clamped value.
- R2: Each 18-bit signed limit L stands for the signal value L*128. The input stage clamps to [x_lim_lo*128, x_lim_hi*128]. The filter result clamps to [y_lim_lo*128, y_lim_hi*128].
- R3: The filter result is `floor((b0*x[n] + b1*x[n-1] + b2*x[n-2] - a1*y[n-1] - a2*y[n-2]) / 2^16)`, where x is the clamped input and y is the clamped output. The feedback uses the clamped output.
- R4: A `sample_valid` accepted in clock cycle k gives a one-cycle `y_valid` pulse in cycle k+7. `y_out`, `saturated` and `railed` change only with that pulse.
- R5: `sample_valid` is ignored during the six cycles after an accepted sample, and produces no extra `y_valid` pulse.
- R6: `saturated` is 1 after a sample if either limiter had to clip that sample's value (value strictly outside its range). Otherwise it is 0.
- R7: `railed` is 1 after a sample if `y_out` equals the lower or the upper output limit. Otherwise it is 0.
- R8: A sample taken with `hold`=1 (and `clear`=0) leaves `y_out` and all four delay states unchanged. Processing resumes from that state on the next sample without hold. In this case `saturated` reflects only the input limiter.
- R9: A sample taken with `clear`=1 zeroes the four delay states before it is computed, so its output is `floor(b0*x/2^16)` clamped. `clear` overrides `hold`.
- R10: After reset, `x_out`, `y_out`, `y_valid`, `saturated`, `railed` and all delay states are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | New input sample strobe |
| in_sample | input | 25 | Signed input sample |
| in_zero | input | 1 | Replace the input sample with zero |
| dx | input | 25 | Signed offset added to the selected input |
| hold | input | 1 | Freeze filter state and output for this sample |
| clear | input | 1 | Zero filter delay states for this sample |
| coef_b0 | input | 36 | Signed feed-forward coefficient, current input |
| coef_b1 | input | 36 | Signed feed-forward coefficient, one sample back |
| coef_b2 | input | 36 | Signed feed-forward coefficient, two samples back |
| coef_a1 | input | 36 | Signed feedback coefficient, one sample back |
| coef_a2 | input | 36 | Signed feedback coefficient, two samples back |
| x_lim_lo | input | 18 | Input limiter lower bound (scaled by 128) |
| x_lim_hi | input | 18 | Input limiter upper bound (scaled by 128) |
| y_lim_lo | input | 18 | Output limiter lower bound (scaled by 128) |
| y_lim_hi | input | 18 | Output limiter upper bound (scaled by 128) |
| x_out | output | 25 | Clamped stage value of the latest sample |
| y_out | output | 25 | Clamped filter output |
| y_valid | output | 1 | One-cycle output strobe |
| saturated | output | 1 | A limiter clipped the latest sample |
| railed | output | 1 | Output sits on an output limit |

## Verification
A pure pass-through gain is applied to positive and negative samples and to the zero-select path with an offset. This separates input-stage faults from filter faults. An extreme sum that would wrap in 25 bits shows whether the extra sum bit is really used. A multi-tap coefficient set with mixed signs, driven by a short step-and-impulse sequence, checks the tap order, the sign of the feedback terms and the use of the clamped feedback. Odd negative and positive inputs at gain one half check that the shift rounds toward negative infinity rather than toward zero. Tight limits, hold, clear, and strobes during the busy window each drive one flag or one state path, and each is compared against a bench model.

// File: rtl/servo_pkg.sv
package servo_pkg;
   // Clock cycles available per sample at 125 MHz * 8/120
   localparam int FRAME_CYCLES = 15;

   // Sequencer steps of the iterative filter: capture, five taps, finish
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_B0   = 3'd1,
      ST_B1   = 3'd2,
      ST_B2   = 3'd3,
      ST_A1   = 3'd4,
      ST_A2   = 3'd5,
      ST_FIN  = 3'd6
   } step_e;

   // Clocks from sample acceptance to output strobe
   localparam int LATENCY = 7;
endpackage

// File: rtl/servo_limiter.sv
module servo_limiter #(
   parameter int IN_W  = 26,
   parameter int OUT_W = 25,
   parameter int LIM_W = 18
) (
   input  logic signed [IN_W-1:0]  din,
   input  logic signed [LIM_W-1:0] lim_lo,
   input  logic signed [LIM_W-1:0] lim_hi,
   output logic signed [OUT_W-1:0] dout,
   output logic signed [OUT_W-1:0] lo_s,
   output logic signed [OUT_W-1:0] hi_s,
   output logic                    clipped
);
   localparam int SH = OUT_W - LIM_W;

   logic signed [IN_W-1:0] lo_ext;
   logic signed [IN_W-1:0] hi_ext;

   generate
      if (LIM_W > OUT_W || IN_W <= OUT_W) begin : g_bad_cfg
         $error("servo_limiter: need LIM_W <= OUT_W < IN_W");
      end
      if (SH == 0) begin : g_direct
         assign lo_ext = {{(IN_W-LIM_W){lim_lo[LIM_W-1]}}, lim_lo};
         assign hi_ext = {{(IN_W-LIM_W){lim_hi[LIM_W-1]}}, lim_hi};
      end else begin : g_scaled
         assign lo_ext = {{(IN_W-OUT_W){lim_lo[LIM_W-1]}}, lim_lo, {SH{1'b0}}};
         assign hi_ext = {{(IN_W-OUT_W){lim_hi[LIM_W-1]}}, lim_hi, {SH{1'b0}}};
      end
   endgenerate

   assign lo_s = lo_ext[OUT_W-1:0];
   assign hi_s = hi_ext[OUT_W-1:0];

   always_comb begin
      if (din > hi_ext) begin
         dout    = hi_ext[OUT_W-1:0];
         clipped = 1'b1;
      end else if (din < lo_ext) begin
         dout    = lo_ext[OUT_W-1:0];
         clipped = 1'b1;
      end else begin
         dout    = din[OUT_W-1:0];
         clipped = 1'b0;
      end
   end
endmodule

// File: rtl/servo_input_stage.sv
module servo_input_stage #(
   parameter int DW    = 25,
   parameter int LIM_W = 18
) (
   input  logic signed [DW-1:0]    in_sample,
   input  logic                    in_zero,
   input  logic signed [DW-1:0]    dx,
   input  logic signed [LIM_W-1:0] lim_lo,
   input  logic signed [LIM_W-1:0] lim_hi,
   output logic signed [DW-1:0]    x_lim,
   output logic                    x_clip
);
   localparam int SUM_W = DW + 1;

   logic signed [SUM_W-1:0] sel_ext;
   logic signed [SUM_W-1:0] dx_ext;
   logic signed [SUM_W-1:0] sum;
   logic signed [DW-1:0]    lo_unused;
   logic signed [DW-1:0]    hi_unused;

   assign sel_ext = in_zero ? '0 : {in_sample[DW-1], in_sample};
   assign dx_ext  = {dx[DW-1], dx};
   assign sum     = sel_ext + dx_ext;

   servo_limiter #(.IN_W(SUM_W), .OUT_W(DW), .LIM_W(LIM_W)) u_xlim (
      .din     (sum),
      .lim_lo  (lim_lo),
      .lim_hi  (lim_hi),
      .dout    (x_lim),
      .lo_s    (lo_unused),
      .hi_s    (hi_unused),
      .clipped (x_clip)
   );
endmodule

// File: rtl/servo_iir2_iter.sv
module servo_iir2_iter
   import servo_pkg::*;
#(
   parameter int DW    = 25,
   parameter int CW    = 36,
   parameter int LIM_W = 18,
   parameter int SHIFT = 16,
   parameter int GUARD = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [DW-1:0]    x_in,
   input  logic                    x_clip,
   input  logic                    hold,
   input  logic                    clear,
   input  logic signed [CW-1:0]    coef_b0,
   input  logic signed [CW-1:0]    coef_b1,
   input  logic signed [CW-1:0]    coef_b2,
   input  logic signed [CW-1:0]    coef_a1,
   input  logic signed [CW-1:0]    coef_a2,
   input  logic signed [LIM_W-1:0] y_lim_lo,
   input  logic signed [LIM_W-1:0] y_lim_hi,
   output logic                    busy,
   output logic signed [DW-1:0]    x_out,
   output logic signed [DW-1:0]    y_out,
   output logic                    y_valid,
   output logic                    saturated,
   output logic                    railed
);
   localparam int PROD_W = CW + DW;
   localparam int ACC_W  = PROD_W + GUARD;

   generate
      if (GUARD < 3 || SHIFT >= ACC_W) begin : g_bad_cfg
         $error("servo_iir2_iter: need GUARD >= 3 and SHIFT < ACC_W");
      end
   endgenerate

   step_e step, step_nx;
   logic signed [DW-1:0]     x1, x2, y1, y2;
   logic                     xsat_q, hold_q, clear_q;
   logic signed [ACC_W-1:0]  acc;
   logic signed [CW-1:0]     mul_c;
   logic signed [DW-1:0]     mul_d;
   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_ext;
   logic                     tap_sub;
   logic signed [ACC_W-1:0]  acc_sh;
   logic signed [DW-1:0]     y_new, y_lo_s, y_hi_s;
   logic                     y_clip;
   logic                     freeze;

   assign busy   = (step != ST_IDLE);
   assign freeze = hold_q && !clear_q;

   // Operand selection for the shared multiplier
   always_comb begin
      mul_c   = '0;
      mul_d   = '0;
      tap_sub = 1'b0;
      step_nx = ST_IDLE;
      case (step)
         ST_B0: begin mul_c = coef_b0; mul_d = x_out; step_nx = ST_B1; end
         ST_B1: begin mul_c = coef_b1; mul_d = x1;    step_nx = ST_B2; end
         ST_B2: begin mul_c = coef_b2; mul_d = x2;    step_nx = ST_A1; end
         ST_A1: begin mul_c = coef_a1; mul_d = y1; tap_sub = 1'b1; step_nx = ST_A2; end
         ST_A2: begin mul_c = coef_a2; mul_d = y2; tap_sub = 1'b1; step_nx = ST_FIN; end
         default: step_nx = ST_IDLE;
      endcase
   end

   assign prod     = mul_c * mul_d;
   assign prod_ext = ACC_W'(prod);
   assign acc_sh   = acc >>> SHIFT;

   servo_limiter #(.IN_W(ACC_W), .OUT_W(DW), .LIM_W(LIM_W)) u_ylim (
      .din     (acc_sh),
      .lim_lo  (y_lim_lo),
      .lim_hi  (y_lim_hi),
      .dout    (y_new),
      .lo_s    (y_lo_s),
      .hi_s    (y_hi_s),
      .clipped (y_clip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step      <= ST_IDLE;
         acc       <= '0;
         x_out     <= '0;
         x1        <= '0;
         x2        <= '0;
         y1        <= '0;
         y2        <= '0;
         y_out     <= '0;
         xsat_q    <= 1'b0;
         hold_q    <= 1'b0;
         clear_q   <= 1'b0;
         y_valid   <= 1'b0;
         saturated <= 1'b0;
         railed    <= 1'b0;
      end else begin
         y_valid <= 1'b0;
         case (step)
            ST_IDLE: begin
               if (start) begin
                  step    <= ST_B0;
                  acc     <= '0;
                  x_out   <= x_in;
                  xsat_q  <= x_clip;
                  hold_q  <= hold;
                  clear_q <= clear;
                  if (clear) begin
                     x1 <= '0;
                     x2 <= '0;
                     y1 <= '0;
                     y2 <= '0;
                  end
               end
            end
            ST_FIN: begin
               step    <= ST_IDLE;
               y_valid <= 1'b1;
               if (!freeze) begin
                  y_out     <= y_new;
                  x1        <= x_out;
                  x2        <= x1;
                  y1        <= y_new;
                  y2        <= y1;
                  saturated <= xsat_q | y_clip;
                  railed    <= (y_new == y_lo_s) || (y_new == y_hi_s);
               end else begin
                  saturated <= xsat_q;
                  railed    <= (y_out == y_lo_s) || (y_out == y_hi_s);
               end
            end
            default: begin
               acc  <= tap_sub ? (acc - prod_ext) : (acc + prod_ext);
               step <= step_nx;
            end
         endcase
      end
   end

   // R9: a cleared sample starts from an empty delay line
   p_clear_zeroes_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_IDLE && start && clear) |=> (x1 == 0 && x2 == 0 && y1 == 0 && y2 == 0));

   // R8: a held sample leaves output and state untouched
   p_hold_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_FIN && freeze) |=> ($stable(y_out) && $stable(y1) && $stable(y2) && $stable(x1) && $stable(x2)));

   // R2: a computed output always lies inside the output limits
   p_y_within_limits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_FIN && !freeze) |=> (y_out <= $past(y_hi_s) && y_out >= $past(y_lo_s)));

   // R4: the output strobe is a single-cycle pulse
   p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |=> !y_valid);

   // R5: no restart while the taps are being accumulated
   p_busy_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step != ST_IDLE && step != ST_FIN) |=> (step != ST_B0));
endmodule

// File: rtl/servo_slow_chain.sv
module servo_slow_chain
   import servo_pkg::*;
#(
   parameter int DW    = 25,
   parameter int CW    = 36,
   parameter int LIM_W = 18,
   parameter int SHIFT = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_valid,
   input  logic signed [DW-1:0]    in_sample,
   input  logic                    in_zero,
   input  logic signed [DW-1:0]    dx,
   input  logic                    hold,
   input  logic                    clear,
   input  logic signed [CW-1:0]    coef_b0,
   input  logic signed [CW-1:0]    coef_b1,
   input  logic signed [CW-1:0]    coef_b2,
   input  logic signed [CW-1:0]    coef_a1,
   input  logic signed [CW-1:0]    coef_a2,
   input  logic signed [LIM_W-1:0] x_lim_lo,
   input  logic signed [LIM_W-1:0] x_lim_hi,
   input  logic signed [LIM_W-1:0] y_lim_lo,
   input  logic signed [LIM_W-1:0] y_lim_hi,
   output logic signed [DW-1:0]    x_out,
   output logic signed [DW-1:0]    y_out,
   output logic                    y_valid,
   output logic                    saturated,
   output logic                    railed
);
   logic signed [DW-1:0] x_lim;
   logic                 x_clip;
   logic                 busy;
   logic                 start;

   assign start = sample_valid && !busy;

   servo_input_stage #(.DW(DW), .LIM_W(LIM_W)) u_in (
      .in_sample (in_sample),
      .in_zero   (in_zero),
      .dx        (dx),
      .lim_lo    (x_lim_lo),
      .lim_hi    (x_lim_hi),
      .x_lim     (x_lim),
      .x_clip    (x_clip)
   );

   servo_iir2_iter #(.DW(DW), .CW(CW), .LIM_W(LIM_W), .SHIFT(SHIFT)) u_iir (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .x_in      (x_lim),
      .x_clip    (x_clip),
      .hold      (hold),
      .clear     (clear),
      .coef_b0   (coef_b0),
      .coef_b1   (coef_b1),
      .coef_b2   (coef_b2),
      .coef_a1   (coef_a1),
      .coef_a2   (coef_a2),
      .y_lim_lo  (y_lim_lo),
      .y_lim_hi  (y_lim_hi),
      .busy      (busy),
      .x_out     (x_out),
      .y_out     (y_out),
      .y_valid   (y_valid),
      .saturated (saturated),
      .railed    (railed)
   );

   // R4: every output strobe follows an accepted sample by the fixed latency
   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      y_valid |-> $past(sample_valid && !busy, 7));
endmodule

// File: tb/servo_slow_chain_tb.sv
module servo_slow_chain_tb_top;
   localparam int CLK_PERIOD = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic sample_valid, in_zero, hold, clear;
   logic signed [24:0] in_sample, dx;
   logic signed [35:0] coef_b0, coef_b1, coef_b2, coef_a1, coef_a2;
   logic signed [17:0] x_lim_lo, x_lim_hi, y_lim_lo, y_lim_hi;
   logic signed [24:0] x_out, y_out;
   logic y_valid, saturated, railed;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   longint c_b0, c_b1, c_b2, c_a1, c_a2;
   longint l_xlo, l_xhi, l_ylo, l_yhi;
   longint m_x1, m_x2, m_y1, m_y2, m_y;

   always #(CLK_PERIOD/2) clk = ~clk;

   servo_slow_chain dut_i (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .in_sample(in_sample), .in_zero(in_zero), .dx(dx),
      .hold(hold), .clear(clear),
      .coef_b0(coef_b0), .coef_b1(coef_b1), .coef_b2(coef_b2),
      .coef_a1(coef_a1), .coef_a2(coef_a2),
      .x_lim_lo(x_lim_lo), .x_lim_hi(x_lim_hi),
      .y_lim_lo(y_lim_lo), .y_lim_hi(y_lim_hi),
      .x_out(x_out), .y_out(y_out), .y_valid(y_valid),
      .saturated(saturated), .railed(railed)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_coefs(input longint b0, input longint b1, input longint b2,
                            input longint a1, input longint a2);
      c_b0 = b0; c_b1 = b1; c_b2 = b2; c_a1 = a1; c_a2 = a2;
      coef_b0 = 36'(b0); coef_b1 = 36'(b1); coef_b2 = 36'(b2);
      coef_a1 = 36'(a1); coef_a2 = 36'(a2);
   endtask

   task automatic set_lims(input longint xlo, input longint xhi, input longint ylo, input longint yhi);
      l_xlo = xlo; l_xhi = xhi; l_ylo = ylo; l_yhi = yhi;
      x_lim_lo = 18'(xlo); x_lim_hi = 18'(xhi);
      y_lim_lo = 18'(ylo); y_lim_hi = 18'(yhi);
   endtask

   // Bench model built from R1, R2, R3, R6, R7, R8 and R9
   task automatic model_step(input longint inv, input bit z, input longint dxv, input bit h, input bit c,
                             output longint xe, output longint ye, output bit se, output bit re);
      longint xs, acc, yr;
      bit xsat, ysat;
      xs = (z ? 0 : inv) + dxv;
      xsat = 1'b0; xe = xs;
      if (xs > l_xhi*128) begin xe = l_xhi*128; xsat = 1'b1; end
      else if (xs < l_xlo*128) begin xe = l_xlo*128; xsat = 1'b1; end
      if (c) begin m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0; end
      if (h && !c) begin
         ye = m_y; se = xsat;
      end else begin
         acc = c_b0*xe + c_b1*m_x1 + c_b2*m_x2 - c_a1*m_y1 - c_a2*m_y2;
         yr = acc >>> 16;
         ysat = 1'b0; ye = yr;
         if (yr > l_yhi*128) begin ye = l_yhi*128; ysat = 1'b1; end
         else if (yr < l_ylo*128) begin ye = l_ylo*128; ysat = 1'b1; end
         m_x2 = m_x1; m_x1 = xe; m_y2 = m_y1; m_y1 = ye; m_y = ye;
         se = xsat | ysat;
      end
      re = (ye == l_ylo*128) || (ye == l_yhi*128);
   endtask

   task automatic run_sample(input longint inv, input bit z, input longint dxv,
                             input bit h, input bit c, input string req);
      longint xe, ye;
      bit se, re;
      int n;
      model_step(inv, z, dxv, h, c, xe, ye, se, re);
      @(negedge clk);
      in_sample = 25'(inv); in_zero = z; dx = 25'(dxv);
      hold = h; clear = c; sample_valid = 1'b1;
      n = 0;
      do begin
         @(posedge clk); n++;
         @(negedge clk); sample_valid = 1'b0;
      end while (!y_valid && n < 20);
      chk("R4", "latency", n, 7);
      chk(req, "y_out", longint'(y_out), ye);
      chk(req, "x_out", longint'(x_out), xe);
      chk(req, "saturated", longint'(saturated), longint'(se));
      chk(req, "railed", longint'(railed), longint'(re));
      hold = 1'b0; clear = 1'b0; in_zero = 1'b0; dx = '0;
      repeat (8) @(negedge clk);
   endtask

   task automatic wide_pass();
      set_lims(-131072, 131071, -131072, 131071);
      set_coefs(65536, 0, 0, 0, 0);
   endtask

   task automatic t_reset();
      chk("R10", "x_out", longint'(x_out), 0);
      chk("R10", "y_out", longint'(y_out), 0);
      chk("R10", "y_valid", longint'(y_valid), 0);
      chk("R10", "saturated", longint'(saturated), 0);
      chk("R10", "railed", longint'(railed), 0);
   endtask

   task automatic t_passthrough();
      wide_pass();
      run_sample(1000, 0, 0, 0, 1, "R3");
      run_sample(-777, 0, 0, 0, 0, "R3");
   endtask

   task automatic t_input_stage();
      wide_pass();
      run_sample(9999, 1, 55, 0, 1, "R1");
      run_sample(300, 0, -100, 0, 0, "R1");
      // R1: sum beyond 25 bits must clamp, not wrap
      run_sample(16777215, 0, 16777215, 0, 0, "R1");
      run_sample(-16777216, 0, -16777216, 0, 0, "R1");
   endtask

   task automatic t_input_limit();
      wide_pass();
      set_lims(-10, 10, -131072, 131071);
      run_sample(5000, 0, 0, 0, 1, "R2");
      run_sample(-5000, 0, 0, 0, 0, "R6");
      run_sample(1280, 0, 0, 0, 0, "R6");
   endtask

   task automatic t_iir();
      set_lims(-131072, 131071, -131072, 131071);
      set_coefs(32768, 16384, -8192, -32768, 4096);
      run_sample(1000, 0, 0, 0, 1, "R3");
      run_sample(-3, 0, 0, 0, 0, "R3");
      run_sample(0, 0, 0, 0, 0, "R3");
      run_sample(517, 0, 0, 0, 0, "R3");
      run_sample(0, 0, 0, 0, 0, "R3");
      run_sample(0, 0, 0, 0, 0, "R3");
   endtask

   task automatic t_floor();
      set_lims(-131072, 131071, -131072, 131071);
      set_coefs(32768, 0, 0, 0, 0);
      run_sample(-3, 0, 0, 0, 1, "R3");
      run_sample(3, 0, 0, 0, 0, "R3");
   endtask

   task automatic t_output_limit();
      wide_pass();
      set_lims(-131072, 131071, -5, 3);
      run_sample(1000, 0, 0, 0, 1, "R7");
      run_sample(384, 0, 0, 0, 0, "R7");
      run_sample(100, 0, 0, 0, 0, "R7");
      run_sample(-2000, 0, 0, 0, 0, "R6");
      // clamped feedback: integrator-like filter rails and stays railed
      set_coefs(65536, 0, 0, -65536, 0);
      run_sample(300, 0, 0, 0, 1, "R3");
      run_sample(300, 0, 0, 0, 0, "R3");
      run_sample(-200, 0, 0, 0, 0, "R3");
   endtask

   task automatic t_hold();
      set_lims(-131072, 131071, -131072, 131071);
      set_coefs(32768, 16384, -8192, -32768, 4096);
      run_sample(2000, 0, 0, 0, 1, "R8");
      run_sample(500, 0, 0, 0, 0, "R8");
      run_sample(-9000, 0, 0, 1, 0, "R8");
      run_sample(-9000, 0, 0, 1, 0, "R8");
      run_sample(100, 0, 0, 0, 0, "R8");
      set_lims(-10, 10, -131072, 131071);
      run_sample(5000, 0, 0, 1, 0, "R8");
   endtask

   task automatic t_clear();
      set_lims(-131072, 131071, -131072, 131071);
      set_coefs(32768, 16384, -8192, -32768, 4096);
      run_sample(3000, 0, 0, 0, 0, "R9");
      run_sample(-700, 0, 0, 0, 0, "R9");
      run_sample(1001, 0, 0, 1, 1, "R9");
      run_sample(40, 0, 0, 0, 0, "R9");
   endtask

   task automatic t_busy();
      longint xe, ye;
      bit se, re;
      int pulses;
      longint ylast;
      wide_pass();
      model_step(1000, 0, 0, 0, 1, xe, ye, se, re);
      @(negedge clk);
      in_sample = 25'(1000); clear = 1'b1; sample_valid = 1'b1;
      pulses = 0; ylast = 0;
      for (int i = 0; i < 25; i++) begin
         @(posedge clk);
         @(negedge clk);
         clear = 1'b0;
         sample_valid = (i == 1 || i == 4);
         if (i >= 1) in_sample = -25'sd50;
         if (y_valid) begin pulses++; ylast = longint'(y_out); end
      end
      sample_valid = 1'b0;
      chk("R5", "y_valid pulses", pulses, 1);
      chk("R5", "y_out", ylast, ye);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R4 watchdog: actual %0d expected %0d", 200000, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0; m_y = 0;
      rst_n = 1'b0; sample_valid = 1'b0; in_zero = 1'b0; hold = 1'b0; clear = 1'b0;
      in_sample = '0; dx = '0;
      wide_pass();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_passthrough();
      t_input_stage();
      t_input_limit();
      t_iir();
      t_floor();
      t_output_limit();
      t_hold();
      t_clear();
      t_busy();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule